// File: doc/BRIEF.md
# Pipeline control staging

This block moves decoded control and the destination register number down a five-stage, 32-bit load/store pipeline (fetch, decode, execute, memory, write-back) together with the data. It holds the fetch-to-decode register, which stores the fetched instruction word. No separate instruction register exists. It also holds the three later stage registers.

An external decoder reads the word in decode and returns three groups of control, one for each consuming stage, plus a destination-field select. Each group is kept only until the stage that uses it. Every stage therefore sees just the control of the instruction it currently holds.

The destination register number is picked in decode and rides along with the result. Write-back uses this number, not the one from the instruction that is in decode at that time. The block also sign-extends the immediate and presents it to the execute stage. Stall and flush inputs turn the entry into the execute stage into a no-operation bubble. A stall also freezes the fetched word and the program-counter enable.

Top module: `pctl_stager`

## Requirements
- R1: When `stall_i` is low at a rising edge, `id_instr_o` shows `fetch_instr_i` from that edge one cycle later.
- R2: While `stall_i` is high, `pc_en_o` is low in the same cycle and `id_instr_o` keeps its value. After the edge, every execute, memory and write-back control output of the stalled slot reads zero as it moves down the pipe.
- R3: When `flush_i` is high at an edge, the slot entering execute carries all-zero control, immediate and destination. It then writes no register and accesses no memory in later stages.
- R4: One cycle after decode, `ex_alu_fn_o` and `ex_use_imm_o` equal the decoder's execute group. `ex_imm_o` equals bits [15:0] of the decoded word, sign-extended from bit 15 to 32 bits.
- R5: The destination number is bits [20:16] of the decoded word when `dec_dst_sel_i` is 0, and bits [15:11] when it is 1.
- R6: Two cycles after decode, `mem_rd_o`, `mem_wr_o` and `mem_branch_o` equal the decoder's memory group for that instruction.
- R7: Three cycles after decode, `wb_from_mem_o` equals that instruction's write-back select and `wb_rnum_o` its destination number.
- R8: `wb_we_o` is high only when the write-back enable is set and the carried destination number is nonzero.
- R9: A synchronous `rst` clears the fetched word and every control field, destination number and immediate to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold fetch/decode, inject bubble into execute |
| flush_i | input | 1 | Inject bubble into execute |
| fetch_instr_i | input | 32 | Instruction word from fetch |
| pc_en_o | output | 1 | Program-counter update enable |
| id_instr_o | output | 32 | Instruction word in decode, to the decoder |
| dec_alu_fn_i | input | 4 | Decoder execute group: ALU function |
| dec_use_imm_i | input | 1 | Decoder execute group: immediate as second operand |
| dec_mem_rd_i | input | 1 | Decoder memory group: load |
| dec_mem_wr_i | input | 1 | Decoder memory group: store |
| dec_branch_i | input | 1 | Decoder memory group: branch |
| dec_wb_en_i | input | 1 | Decoder write-back group: register write |
| dec_wb_from_mem_i | input | 1 | Decoder write-back group: result from memory |
| dec_dst_sel_i | input | 1 | Destination field select (0: [20:16], 1: [15:11]) |
| ex_alu_fn_o | output | 4 | ALU function of the execute slot |
| ex_use_imm_o | output | 1 | Immediate select of the execute slot |
| ex_imm_o | output | 32 | Sign-extended immediate of the execute slot |
| mem_rd_o | output | 1 | Load of the memory slot |
| mem_wr_o | output | 1 | Store of the memory slot |
| mem_branch_o | output | 1 | Branch of the memory slot |
| wb_from_mem_o | output | 1 | Write-back select of the write-back slot |
| wb_we_o | output | 1 | Register write enable, gated for register 0 |
| wb_rnum_o | output | 5 | Destination register of the write-back slot |

## Verification
The assertions assume that the decoder inputs are a function of `id_instr_o` settled before each edge. They also assume that reset lasts at least one edge and that stall and flush are sampled only at edges. The bench keeps to these rules with a combinational stub decoder that reads `id_instr_o` directly. Stall, flush, reset and the fetched word change only on the falling edge. Pseudo-random streams then mix stalls, flushes, a mid-run reset and writes to register 0.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
    localparam int XLEN     = 32;
    localparam int RNUM_W   = 5;
    localparam int ALU_FN_W = 4;
    localparam int IMM_W    = 16;
    localparam int RT_LSB   = 16;
    localparam int RD_LSB   = 11;

    typedef struct packed {
        logic [ALU_FN_W-1:0] alu_fn;
        logic                use_imm;
    } ex_ctl_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic br;
    } mem_ctl_t;

    typedef struct packed {
        logic wr_en;
        logic from_mem;
    } wb_ctl_t;
endpackage

// File: rtl/pctl_fetch_reg.sv
module pctl_fetch_reg import pctl_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_i,
    input  logic [XLEN-1:0] instr_i,
    output logic [XLEN-1:0] instr_o
);
    typedef struct packed {
        logic [XLEN-1:0] instr;
    } fd_state_t;

    fd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!stall_i) st_d.instr = instr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign instr_o = st_q.instr;

    // R2: a stalled edge leaves the decode word untouched
    p_hold_on_stall_r2: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(instr_o));
endmodule

// File: rtl/pctl_exec_reg.sv
module pctl_exec_reg import pctl_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              bubble_i,
    input  logic [XLEN-1:0]   instr_i,
    input  logic              dst_sel_i,
    input  ex_ctl_t           ex_i,
    input  mem_ctl_t          mem_i,
    input  wb_ctl_t           wb_i,
    output ex_ctl_t           ex_o,
    output mem_ctl_t          mem_o,
    output wb_ctl_t           wb_o,
    output logic [RNUM_W-1:0] dst_o,
    output logic [XLEN-1:0]   imm_o
);
    localparam int EXT_W = XLEN - IMM_W;

    typedef struct packed {
        ex_ctl_t           ex;
        mem_ctl_t          mem;
        wb_ctl_t           wb;
        logic [RNUM_W-1:0] dst;
        logic [XLEN-1:0]   imm;
    } de_state_t;

    de_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (!bubble_i) begin
            st_d.ex  = ex_i;
            st_d.mem = mem_i;
            st_d.wb  = wb_i;
            st_d.dst = dst_sel_i ? instr_i[RD_LSB +: RNUM_W] : instr_i[RT_LSB +: RNUM_W];
            st_d.imm = {{EXT_W{instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ex_o  = st_q.ex;
    assign mem_o = st_q.mem;
    assign wb_o  = st_q.wb;
    assign dst_o = st_q.dst;
    assign imm_o = st_q.imm;

    // R3: a bubble carries no effect into later stages
    p_bubble_empty_r3: assert property (@(posedge clk) disable iff (rst)
        bubble_i |=> (ex_o == '0 && mem_o == '0 && wb_o == '0 && dst_o == '0));

    // R4: upper immediate bits all copy the sign bit
    p_imm_sext_r4: assert property (@(posedge clk) disable iff (rst)
        !bubble_i |=> ((&imm_o[XLEN-1:IMM_W-1]) || !(|imm_o[XLEN-1:IMM_W-1])));
endmodule

// File: rtl/pctl_mem_reg.sv
module pctl_mem_reg import pctl_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  mem_ctl_t          mem_i,
    input  wb_ctl_t           wb_i,
    input  logic [RNUM_W-1:0] dst_i,
    output mem_ctl_t          mem_o,
    output wb_ctl_t           wb_o,
    output logic [RNUM_W-1:0] dst_o
);
    typedef struct packed {
        mem_ctl_t          mem;
        wb_ctl_t           wb;
        logic [RNUM_W-1:0] dst;
    } em_state_t;

    em_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.mem = mem_i;
        st_d.wb  = wb_i;
        st_d.dst = dst_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mem_o = st_q.mem;
    assign wb_o  = st_q.wb;
    assign dst_o = st_q.dst;
endmodule

// File: rtl/pctl_wb_reg.sv
module pctl_wb_reg import pctl_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  wb_ctl_t           wb_i,
    input  logic [RNUM_W-1:0] dst_i,
    output logic              from_mem_o,
    output logic              we_o,
    output logic [RNUM_W-1:0] dst_o
);
    typedef struct packed {
        wb_ctl_t           wb;
        logic [RNUM_W-1:0] dst;
    } mw_state_t;

    mw_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.wb  = wb_i;
        st_d.dst = dst_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign from_mem_o = st_q.wb.from_mem;
    assign dst_o      = st_q.dst;
    assign we_o       = st_q.wb.wr_en && (st_q.dst != '0);
endmodule

// File: rtl/pctl_stager.sv
module pctl_stager import pctl_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                stall_i,
    input  logic                flush_i,
    input  logic [XLEN-1:0]     fetch_instr_i,
    output logic                pc_en_o,
    output logic [XLEN-1:0]     id_instr_o,
    input  logic [ALU_FN_W-1:0] dec_alu_fn_i,
    input  logic                dec_use_imm_i,
    input  logic                dec_mem_rd_i,
    input  logic                dec_mem_wr_i,
    input  logic                dec_branch_i,
    input  logic                dec_wb_en_i,
    input  logic                dec_wb_from_mem_i,
    input  logic                dec_dst_sel_i,
    output logic [ALU_FN_W-1:0] ex_alu_fn_o,
    output logic                ex_use_imm_o,
    output logic [XLEN-1:0]     ex_imm_o,
    output logic                mem_rd_o,
    output logic                mem_wr_o,
    output logic                mem_branch_o,
    output logic                wb_from_mem_o,
    output logic                wb_we_o,
    output logic [RNUM_W-1:0]   wb_rnum_o
);
    ex_ctl_t           dec_ex, de_ex;
    mem_ctl_t          dec_mem, de_mem, em_mem;
    wb_ctl_t           dec_wb, de_wb, em_wb;
    logic [RNUM_W-1:0] de_dst, em_dst;
    logic              bubble;

    assign pc_en_o = !stall_i;
    assign bubble  = stall_i || flush_i;

    always_comb begin
        dec_ex.alu_fn   = dec_alu_fn_i;
        dec_ex.use_imm  = dec_use_imm_i;
        dec_mem.rd      = dec_mem_rd_i;
        dec_mem.wr      = dec_mem_wr_i;
        dec_mem.br      = dec_branch_i;
        dec_wb.wr_en    = dec_wb_en_i;
        dec_wb.from_mem = dec_wb_from_mem_i;
    end

    pctl_fetch_reg u_fd (
        .clk(clk), .rst(rst), .stall_i(stall_i),
        .instr_i(fetch_instr_i), .instr_o(id_instr_o)
    );

    pctl_exec_reg u_de (
        .clk(clk), .rst(rst), .bubble_i(bubble), .instr_i(id_instr_o),
        .dst_sel_i(dec_dst_sel_i), .ex_i(dec_ex), .mem_i(dec_mem), .wb_i(dec_wb),
        .ex_o(de_ex), .mem_o(de_mem), .wb_o(de_wb), .dst_o(de_dst), .imm_o(ex_imm_o)
    );

    pctl_mem_reg u_em (
        .clk(clk), .rst(rst), .mem_i(de_mem), .wb_i(de_wb), .dst_i(de_dst),
        .mem_o(em_mem), .wb_o(em_wb), .dst_o(em_dst)
    );

    pctl_wb_reg u_mw (
        .clk(clk), .rst(rst), .wb_i(em_wb), .dst_i(em_dst),
        .from_mem_o(wb_from_mem_o), .we_o(wb_we_o), .dst_o(wb_rnum_o)
    );

    assign ex_alu_fn_o  = de_ex.alu_fn;
    assign ex_use_imm_o = de_ex.use_imm;
    assign mem_rd_o     = em_mem.rd;
    assign mem_wr_o     = em_mem.wr;
    assign mem_branch_o = em_mem.br;

    // R6: memory group moves from the execute slot into the memory slot
    p_mem_follows_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ({mem_rd_o, mem_wr_o, mem_branch_o} == $past(de_mem)));

    // R7: write-back number is the one carried from the memory slot
    p_rnum_follows_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wb_rnum_o == $past(em_dst)));

    // R8: no register write reaches register 0
    p_no_r0_write_r8: assert property (@(posedge clk) disable iff (rst)
        wb_we_o |-> ($past(em_dst) != '0 && $past(em_wb.wr_en)));

    // R9: reset leaves every stage empty
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (id_instr_o == '0 && ex_alu_fn_o == '0 && !ex_use_imm_o &&
                        ex_imm_o == '0 && !mem_rd_o && !mem_wr_o && !mem_branch_o &&
                        !wb_from_mem_o && !wb_we_o && wb_rnum_o == '0));
endmodule

// File: tb/pctl_stager_tb.sv
module pctl_stager_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] fetch = '0;
    logic        pc_en;
    logic [31:0] id_instr;
    logic [3:0]  ex_alu_fn;
    logic        ex_use_imm;
    logic [31:0] ex_imm;
    logic        mem_rd, mem_wr, mem_br, wb_from_mem, wb_we;
    logic [4:0]  wb_rnum;

    // stub decoder: bits 3:0 alu fn, 26 use imm, 27 load (and result from memory),
    // 28 store (ignored with 27), 29 branch, 30 register write, 31 destination select
    logic [3:0] d_fn;
    logic d_imm, d_rd, d_wr, d_br, d_wen, d_fm, d_sel;
    assign d_fn  = id_instr[3:0];
    assign d_imm = id_instr[26];
    assign d_rd  = id_instr[27];
    assign d_wr  = id_instr[28] & ~id_instr[27];
    assign d_br  = id_instr[29];
    assign d_wen = id_instr[30];
    assign d_fm  = id_instr[27];
    assign d_sel = id_instr[31];

    always #(CLK_PERIOD/2) clk = ~clk;

    pctl_stager u_dut (
        .clk(clk), .rst(rst), .stall_i(stall), .flush_i(flush), .fetch_instr_i(fetch),
        .pc_en_o(pc_en), .id_instr_o(id_instr),
        .dec_alu_fn_i(d_fn), .dec_use_imm_i(d_imm), .dec_mem_rd_i(d_rd),
        .dec_mem_wr_i(d_wr), .dec_branch_i(d_br), .dec_wb_en_i(d_wen),
        .dec_wb_from_mem_i(d_fm), .dec_dst_sel_i(d_sel),
        .ex_alu_fn_o(ex_alu_fn), .ex_use_imm_o(ex_use_imm), .ex_imm_o(ex_imm),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_branch_o(mem_br),
        .wb_from_mem_o(wb_from_mem), .wb_we_o(wb_we), .wb_rnum_o(wb_rnum)
    );

    // reference: instruction words per slot plus why a slot is empty
    // why: 0 live, 1 stall bubble, 2 flush bubble, 3 reset
    logic [31:0] m_fd;
    logic [31:0] m_ins [3];
    int          m_why [3];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_fd = '0;
            for (int i = 0; i < 3; i++) begin m_ins[i] = '0; m_why[i] = 3; end
        end else begin
            m_ins[2] = m_ins[1]; m_why[2] = m_why[1];
            m_ins[1] = m_ins[0]; m_why[1] = m_why[0];
            if (stall)      begin m_ins[0] = '0; m_why[0] = 1; end
            else if (flush) begin m_ins[0] = '0; m_why[0] = 2; end
            else            begin m_ins[0] = m_fd; m_why[0] = 0; end
            if (!stall) m_fd = fetch;
        end
    end

    function automatic string tag_of(int why, string live);
        case (why)
            1: return "R2";
            2: return "R3";
            3: return "R9";
            default: return live;
        endcase
    endfunction

    function automatic logic [4:0] dst_of(logic [31:0] w);
        return w[31] ? w[15:11] : w[20:16];
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_regs();
        logic [31:0] e, m, w;
        e = m_ins[0]; m = m_ins[1]; w = m_ins[2];
        chk(m_why[2] == 3 ? "R9" : "R1", "id_instr", id_instr, m_fd);
        chk(tag_of(m_why[0], "R4"), "ex_alu_fn", 32'(ex_alu_fn), 32'(e[3:0]));
        chk(tag_of(m_why[0], "R4"), "ex_use_imm", 32'(ex_use_imm), 32'(e[26]));
        chk(tag_of(m_why[0], "R4"), "ex_imm", ex_imm, {{16{e[15]}}, e[15:0]});
        chk(tag_of(m_why[1], "R6"), "mem_rd", 32'(mem_rd), 32'(m[27]));
        chk(tag_of(m_why[1], "R6"), "mem_wr", 32'(mem_wr), 32'(m[28] & ~m[27]));
        chk(tag_of(m_why[1], "R6"), "mem_branch", 32'(mem_br), 32'(m[29]));
        chk(tag_of(m_why[2], "R7"), "wb_from_mem", 32'(wb_from_mem), 32'(w[27]));
        chk(tag_of(m_why[2], "R5"), "wb_rnum", 32'(wb_rnum), 32'(dst_of(w)));
        chk(tag_of(m_why[2], "R8"), "wb_we", 32'(wb_we), 32'(w[30] && dst_of(w) != 5'd0));
    endtask

    task automatic step(logic r, logic st, logic fl, logic [31:0] ins);
        @(negedge clk);
        check_regs();
        rst = r; stall = st; flush = fl; fetch = ins;
        #1;
        chk("R2", "pc_en", 32'(pc_en), 32'(!st));
    endtask

    function automatic logic [31:0] mk(logic sel, logic wen, logic ld, logic stv, logic br,
                                       logic [4:0] rt, logic [4:0] rd, logic [15:0] imm);
        logic [31:0] w;
        w = {sel, wen, br, stv, ld, 1'b1, 5'd7, rt, imm};
        w[15:11] = rd;
        return w;
    endfunction

    logic [31:0] lfsr = 32'h1ACE_B00C;
    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        step(1, 0, 0, '0);
        // directed: load to r9 via [20:16], result to r12 via [15:11], write to r0,
        // store, branch, negative immediate
        step(0, 0, 0, mk(0, 1, 1, 0, 0, 5'd9, 5'd3, 16'h0010));
        step(0, 0, 0, mk(1, 1, 0, 0, 0, 5'd4, 5'd12, 16'h6000));
        step(0, 0, 0, mk(0, 1, 0, 0, 0, 5'd0, 5'd5, 16'h0001));
        step(0, 0, 0, mk(1, 1, 0, 0, 0, 5'd7, 5'd0, 16'h0002));
        step(0, 0, 0, mk(0, 0, 0, 1, 0, 5'd8, 5'd1, 16'hFFF0));
        step(0, 0, 0, mk(0, 0, 0, 0, 1, 5'd2, 5'd2, 16'h8000));
        step(0, 0, 1, mk(0, 1, 1, 0, 0, 5'd11, 5'd1, 16'h1234));
        step(0, 1, 0, mk(1, 1, 0, 0, 0, 5'd13, 5'd14, 16'h4321));
        step(0, 1, 1, mk(1, 1, 0, 0, 0, 5'd15, 5'd16, 16'h0003));
        step(0, 0, 0, mk(1, 1, 1, 0, 0, 5'd17, 5'd18, 16'hABCD));
        for (int k = 0; k < 6; k++) step(0, 0, 0, '0);
        for (int k = 0; k < RAND_CYCLES; k++) begin
            logic [31:0] a;
            lfsr = nxt(lfsr); a = lfsr;
            lfsr = nxt(lfsr);
            step(k == RAND_CYCLES/2, a[2:0] == 3'd0, a[6:4] == 3'd1, lfsr);
        end
        for (int k = 0; k < 4; k++) step(0, 0, 0, '0);
        @(negedge clk);
        check_regs();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule